// File: doc/BRIEF.md
# Multi-Level Daisy-Chained Bus Arbiter

This block models the arbitration path of a multi-master backplane: one central arbiter, placed at the first slot position, and a requester in every slot. Each slot is assigned one of four request levels. A slot that wants the bus raises the request line of its level. The arbiter watches the four request lines and a shared bus-busy line. It then drives exactly one of four grant lines, one per level. Each grant line passes through the slots in order, starting at slot 0, which sits next to the arbiter. A slot that is requesting on that level keeps the grant. Every other slot passes the grant on to the next slot. The slot that keeps the grant becomes the bus owner, asserts bus-busy and drops its request. The arbiter then withdraws the grant and waits for bus-busy to clear before it arbitrates again.

The arbiter has three modes: fixed priority by level, rotating priority across levels, and a single-level mode. Each slot has its own release policy. A release-when-done slot frees the bus at the end of its transfer. A release-on-request slot keeps the bus after its transfer until some request line is active. Each slot also has a fairness option. With fairness on, the slot raises a new request only while the request line of its level is quiet.

Top module: `backplane_arbiter`

## Requirements
- R1: While reset is low, no request, grant, busy, pending or owner output is asserted.
- R2: At most one grant line and at most one slot owner are active at any time, and `bus_busy` is high exactly when some slot owns the bus.
- R3: When a grant on level L reaches the slots, the lowest-numbered slot that is pending on level L becomes owner at the next edge. Slot levels use field `slot_lvl[2i+1:2i]` for slot i.
- R4: In mode 0 (and in mode 3), the arbiter grants the highest-numbered level whose request line is active. Grant bit L stands for level L.
- R5: In mode 1, the arbiter searches the levels upward from a rotating start level, wrapping from 3 to 0. The start level is 0 after reset, and after each grant it becomes the granted level plus one.
- R6: In mode 2, only level 3 is ever granted, and requests on levels 0 to 2 are never granted.
- R7: The arbiter raises a grant one edge after it sees an active request while bus-busy is low and no grant is active.
- R8: Once the bus is busy, the active grant drops at the next edge. A grant never drops while the bus is idle.
- R9: A slot with `hold_policy` = 0 that owns the bus releases it at the edge where its `xfer_end` is high.
- R10: A slot with `hold_policy` = 1 keeps ownership after its transfer ends. It releases at the first edge where its transfer has ended (now or earlier) and some request line is active.
- R11: A slot that neither requests nor owns raises its request at the next edge when `want_bus` is high, unless R12 holds it off. While it is pending or owning, `want_bus` has no effect.
- R12: A slot with `fair_en` = 1 does not raise its request while the request line of its own level is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arb_mode | input | 2 | 0/3 fixed priority, 1 rotating, 2 single level (level 3) |
| slot_lvl | input | 2*SLOTS | Request level of each slot, two bits per slot |
| want_bus | input | SLOTS | Slot wants a bus tenure |
| xfer_end | input | SLOTS | Owner's current transfer finishes this cycle |
| hold_policy | input | SLOTS | 0 release when done, 1 release on request |
| fair_en | input | SLOTS | Per-slot fairness enable |
| bus_req | output | 4 | Request lines, one per level |
| bus_grant | output | 4 | Arbiter grant lines, one per level |
| bus_busy | output | 1 | Bus held by an owner |
| slot_pend | output | SLOTS | Slot is requesting |
| slot_owner | output | SLOTS | Slot owns the bus |

## Verification
The assertions assume that `arb_mode`, `slot_lvl`, `hold_policy` and `fair_en` change only while reset is held. For example, the single-level check reads the present mode. The stimulus follows this by reconfiguring the block only inside a reset sequence. Between resets it randomizes only `want_bus` and `xfer_end`. `xfer_end` is treated as meaningful only for the owning slot, and stray pulses on other slots must have no effect; the bench drives them freely. The directed cases cover same-level contention, a release-on-request hold and a fairness hold-off.

// File: rtl/backplane_arbiter.sv
module backplane_arbiter #(
  parameter int SLOTS = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         arb_mode,
  input  logic [2*SLOTS-1:0] slot_lvl,
  input  logic [SLOTS-1:0]   want_bus,
  input  logic [SLOTS-1:0]   xfer_end,
  input  logic [SLOTS-1:0]   hold_policy,
  input  logic [SLOTS-1:0]   fair_en,
  output logic [3:0]         bus_req,
  output logic [3:0]         bus_grant,
  output logic               bus_busy,
  output logic [SLOTS-1:0]   slot_pend,
  output logic [SLOTS-1:0]   slot_owner
);
  localparam int LEVELS = 4;

  logic [SLOTS-1:0]  req_q, own_q;
  logic [LEVELS-1:0] chain [0:SLOTS];
  logic [LEVELS-1:0] bg_q, pick;
  logic [1:0]        rr_q, pick_lvl;

  assign bus_busy   = |own_q;
  assign bus_grant  = bg_q;
  assign slot_pend  = req_q;
  assign slot_owner = own_q;
  assign chain[0]   = bg_q;

  always_comb begin
    bus_req = '0;
    for (int i = 0; i < SLOTS; i++)
      bus_req[slot_lvl[2*i +: 2]] = bus_req[slot_lvl[2*i +: 2]] | req_q[i];
  end

  always_comb begin
    logic [1:0] l;
    pick = '0;
    case (arb_mode)
      2'd1:
        for (int k = 0; k < LEVELS; k++) begin
          l = rr_q + 2'(k);
          if (pick == '0 && bus_req[l]) pick[l] = 1'b1;
        end
      2'd2: pick[3] = bus_req[3];
      default:
        for (int k = LEVELS - 1; k >= 0; k--)
          if (pick == '0 && bus_req[k]) pick[k] = 1'b1;
    endcase
  end

  always_comb begin
    pick_lvl = '0;
    for (int k = 0; k < LEVELS; k++)
      if (pick[k]) pick_lvl = 2'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_q <= '0;
      rr_q <= '0;
    end else if (bg_q != '0) begin
      if (bus_busy) bg_q <= '0;
    end else if (!bus_busy && pick != '0) begin
      bg_q <= pick;
      rr_q <= pick_lvl + 2'd1;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [1:0] lv;
    logic r_q, o_q, done_q, take, drop;

    assign lv  = slot_lvl[2*i +: 2];
    assign chain[i+1] = chain[i] & ~({LEVELS{r_q | o_q}} & (4'b0001 << lv));
    assign take = r_q & chain[i][lv] & ~bus_busy;
    assign drop = hold_policy[i] ? ((done_q | xfer_end[i]) & (|bus_req))
                                 : xfer_end[i];
    assign req_q[i] = r_q;
    assign own_q[i] = o_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q    <= 1'b0;
        o_q    <= 1'b0;
        done_q <= 1'b0;
      end else if (o_q) begin
        if (drop) begin
          o_q    <= 1'b0;
          done_q <= 1'b0;
        end else begin
          done_q <= done_q | xfer_end[i];
        end
      end else if (take) begin
        r_q    <= 1'b0;
        o_q    <= 1'b1;
        done_q <= 1'b0;
      end else if (!r_q && want_bus[i] && !(fair_en[i] && bus_req[lv])) begin
        r_q <= 1'b1;
      end
    end

    // R9
    rwd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_q && !hold_policy[i] && xfer_end[i]) |=> !o_q);

    // R12
    fair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fair_en[i] && !r_q && !o_q && bus_req[lv]) |=> !r_q);

    // R2
    own_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_q && o_q));
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant) && $onehot0(slot_owner));

  // R7
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant != '0 && $past(bus_grant) == '0) |-> !$past(bus_busy));

  // R8
  grant_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_grant) != '0 && bus_grant == '0) |-> $past(bus_busy));

  // R6
  single_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_mode == 2'd2) |-> (bus_grant[2:0] == 3'b000));
endmodule

// File: tb/test_backplane_arbiter.sv
`timescale 1ns/1ps
module test_backplane_arbiter;
  localparam int N = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2*N-1:0] lvl = '0;
  logic [N-1:0] want = '0, xend = '0, hold = '0, fair = '0;
  logic [3:0] bus_req, bus_grant;
  logic bus_busy;
  logic [N-1:0] pend, owner;

  backplane_arbiter #(.SLOTS(N)) i_backplane_arbiter (
    .clk(clk), .rst_n(rst_n), .arb_mode(mode), .slot_lvl(lvl),
    .want_bus(want), .xfer_end(xend), .hold_policy(hold), .fair_en(fair),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_busy(bus_busy),
    .slot_pend(pend), .slot_owner(owner));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, chk_en = 0;
  logic [3:0] p_req = '0, p_grant = '0;
  logic p_busy = 0;
  logic [N-1:0] p_pend = '0, p_owner = '0, a_want = '0, a_xend = '0;
  logic [N-1:0] n_want = '0, n_xend = '0;
  int rr_m = 0;
  bit b_done = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_level(logic [1:0] m, logic [3:0] r, int rr);
    if (m == 2'd1) begin
      for (int k = 0; k < 4; k++) if (r[(rr + k) % 4]) return (rr + k) % 4;
      return -1;
    end
    if (m == 2'd2) return r[3] ? 3 : -1;
    for (int l = 3; l >= 0; l--) if (r[l]) return l;
    return -1;
  endfunction

  function automatic int onehot_idx(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int lvl_of(int s);
    return int'(lvl[2*s +: 2]);
  endfunction

  task automatic step();
    @(negedge clk);
    if (!rst_n) begin
      check(bus_req == 0 && bus_grant == 0 && !bus_busy && pend == 0 && owner == 0,
            "R1", "outputs in reset", {bus_req, bus_grant, pend}, 0);
    end else if (chk_en) begin
      check($countones(bus_grant) <= 1 && $countones(owner) <= 1, "R2",
            "single grant/owner", {bus_grant, owner}, 0);
      check(bus_busy == (owner != 0), "R2", "busy vs owner", bus_busy, owner != 0);
      if (p_grant == 0 && !p_busy) begin
        int e;
        string tg;
        e = exp_level(mode, p_req, rr_m);
        tg = (mode == 2'd1) ? "R5" : (mode == 2'd2) ? "R6" : "R4";
        check(bus_grant == ((e < 0) ? 4'b0 : 4'(1 << e)), e < 0 ? "R7" : tg,
              "grant level", bus_grant, (e < 0) ? 0 : (1 << e));
        if (e >= 0) rr_m = (e + 1) % 4;
      end
      if (p_grant != 0)
        check((bus_grant == 0) == p_busy, "R8", "grant drop on busy", bus_grant, p_busy ? 0 : p_grant);
      if (p_owner == 0 && p_grant != 0) begin
        int gl, w;
        logic [N-1:0] ex;
        gl = 0;
        for (int l = 0; l < 4; l++) if (p_grant[l]) gl = l;
        w = -1;
        for (int i = N - 1; i >= 0; i--) if (p_pend[i] && lvl_of(i) == gl) w = i;
        ex = (w < 0) ? '0 : (N'(1) << w);
        check(owner == ex, "R3", "daisy-chain winner", owner, ex);
        b_done = 0;
      end else if (p_owner != 0) begin
        int s;
        bit rel;
        s = onehot_idx(p_owner);
        rel = hold[s] ? ((b_done || a_xend[s]) && p_req != 0) : a_xend[s];
        check(owner == (rel ? '0 : p_owner), hold[s] ? "R10" : "R9",
              "owner release", owner, rel ? 0 : p_owner);
        b_done = rel ? 0 : (b_done | a_xend[s]);
      end
      for (int i = 0; i < N; i++) begin
        if (!p_pend[i] && !p_owner[i]) begin
          bit ex;
          ex = a_want[i] && !(fair[i] && p_req[lvl_of(i)]);
          check(pend[i] == ex, (fair[i] && a_want[i] && p_req[lvl_of(i)]) ? "R12" : "R11",
                $sformatf("request entry slot %0d", i), pend[i], ex);
        end else if (p_pend[i] && !owner[i]) begin
          check(pend[i], "R11", $sformatf("pending held slot %0d", i), pend[i], 1);
        end
      end
    end
    p_req = bus_req; p_grant = bus_grant; p_busy = bus_busy;
    p_pend = pend; p_owner = owner;
    want = n_want; xend = n_xend;
    a_want = n_want; a_xend = n_xend;
  endtask

  task automatic do_reset(logic [1:0] m, logic [2*N-1:0] l, logic [N-1:0] h, logic [N-1:0] f);
    chk_en = 0;
    rst_n = 0;
    n_want = '0; n_xend = '0;
    mode = m; lvl = l; hold = h; fair = f;
    repeat (3) step();
    rst_n = 1;
    rr_m = 0; b_done = 0;
    chk_en = 1;
  endtask

  task automatic wait_owner(logic [N-1:0] target, string req);
    int n;
    n = 0;
    while (owner != target && n < 30) begin step(); n++; end
    check(owner == target, req, "directed owner", owner, target);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R3: two slots on the same level, nearer slot wins, farther follows
    do_reset(2'd0, {N{2'd1}}, '0, '0);
    n_want = (N'(1) << 3) | (N'(1) << 7); step();
    n_want = '0;
    wait_owner(N'(1) << 3, "R3");
    n_xend = N'(1) << 3; step(); n_xend = '0;
    wait_owner(N'(1) << 7, "R3");
    n_xend = N'(1) << 7; step(); n_xend = '0;
    repeat (4) step();

    // R10: release-on-request owner holds an idle bus
    do_reset(2'd0, '0, N'(1) << 2, '0);
    n_want = N'(1) << 2; step(); n_want = '0;
    wait_owner(N'(1) << 2, "R10");
    n_xend = N'(1) << 2; step(); n_xend = '0;
    for (int k = 0; k < 10; k++) begin
      step();
      check(owner == (N'(1) << 2), "R10", "holds idle bus", owner, N'(1) << 2);
    end
    n_want = N'(1) << 5; step(); n_want = '0;
    wait_owner(N'(1) << 5, "R10");
    n_xend = N'(1) << 5; step(); n_xend = '0;
    repeat (4) step();

    // R12: fairness keeps a second slot off a busy request line
    do_reset(2'd2, {N{2'd2}}, '0, '1);
    n_want = N'(1) << 4; step();
    n_want = N'(1) << 6; step();
    check(pend[4] && !pend[6], "R12", "second requester held off", pend, N'(1) << 4);
    n_want = '0;
    repeat (5) step();
    check(owner == 0 && pend[4], "R6", "level 2 never granted in mode 2", owner, 0);

    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      logic [2*N-1:0] rl;
      logic [N-1:0] rh, rf;
      for (int i = 0; i < N; i++) begin
        rl[2*i +: 2] = 2'($urandom_range(0, 3));
        rh[i] = 1'($urandom_range(0, 1));
        rf[i] = 1'($urandom_range(0, 1));
      end
      do_reset(2'(ph % 3), rl, rh, rf);
      for (int c = 0; c < 2500; c++) begin
        for (int i = 0; i < N; i++) begin
          n_want[i] = ($urandom_range(0, 15) == 0);
          n_xend[i] = ($urandom_range(0, 3) == 0);
        end
        step();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule